// File: doc/BRIEF.md
# Banked Data Memory Address Resolver

This unit turns the file-register field of a decoded instruction into a 9-bit data memory address. The address is either direct or indirect. A direct access puts two bank-select bits from the status byte above the 7-bit file field. A file field of zero is not a real register. It selects indirect access: the 8-bit pointer register forms the low byte, and a third status bit forms the top address bit.

The resolved address is then decoded into a region code. The code says whether the access hits general-purpose SRAM or one of the special registers. Some special registers appear at the same offset in both banks. Others exist in only one bank.

The register file returns read data for the address on `addr_o`. On a load strobe, that value is captured into an operand register that feeds the ALU. Unmapped addresses are captured as zero.

The unit also decodes the bit-number field into a one-hot mask for bit-oriented instructions. It supplies the complement of that mask for clearing a bit.

Top module: `dmem_addr_resolver`

## Requirements
- R1: When `instr_i[6:0]` is non-zero, `indirect_o` is 0 and `addr_o` equals `{status_i[6:5], instr_i[6:0]}`. `status_i[7]` has no effect on it.
- R2: When `instr_i[6:0]` is zero, `indirect_o` is 1 and `addr_o` equals `{status_i[7], ptr_i}`. `status_i[6:5]` have no effect on it.
- R3: Region decoding uses only `addr_o[7:0]`, so `addr_o[8]` never changes `region_o`. The region codes are: 0 unmapped, 1 SRAM, 2 program counter low byte, 3 status, 4 pointer, 5 to 8 port A to D, 9 to 12 direction A to D, 13 program counter high latch, 14 interrupt control, 15 option.
- R4: Any `addr_o[6:0]` in 0x0E..0x7F gives region 1 (SRAM) in both halves of the low byte.
- R5: Mirrored registers decode to the same code at offset x and at x|0x80. The pairs are 0x02 → 2, 0x03 → 3, 0x04 → 4, 0x0A → 13 and 0x0B → 14.
- R6: Bank-specific registers decode as follows: 0x05 → 5, 0x06 → 6, 0x0C → 7, 0x0D → 8, 0x85 → 9, 0x86 → 10, 0x8C → 11, 0x8D → 12 and 0x81 → 15.
- R7: Every other low byte gives region 0. These include 0x00, 0x01, 0x07..0x09, 0x80 and 0x87..0x89.
- R8: When `ld_i` is 1 at a rising clock edge, `operand_o` takes `rd_data_i` if the region is non-zero, and 0 if the region is 0. When `ld_i` is 0, `operand_o` holds its value.
- R9: `bit_mask_o` is one-hot with bit `instr_i[9:7]` set. `bit_mask_n_o` is its bitwise complement.
- R10: While `rst_ni` is low, `operand_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 14 | Decoded instruction word |
| status_i | input | 8 | Status byte; bits 7:5 carry the bank selects |
| ptr_i | input | 8 | Indirect pointer register value |
| rd_data_i | input | 8 | Register file read data for `addr_o` |
| ld_i | input | 1 | Operand capture strobe |
| addr_o | output | 9 | Resolved data memory address |
| indirect_o | output | 1 | High when the access is indirect |
| region_o | output | 4 | Region code (see R3) |
| operand_o | output | 8 | Captured ALU operand |
| bit_mask_o | output | 8 | One-hot bit select mask |
| bit_mask_n_o | output | 8 | Complement of the bit select mask |

## Verification
The assertions assume that `rd_data_i` is valid combinationally for the current `addr_o` on the cycle `ld_i` is high. They also assume that `instr_i`, `status_i` and `ptr_i` are steady across each rising edge. The bench drives every input on the falling edge only, so both assumptions hold. It raises `ld_i` for single cycles with a known read value, which keeps each capture attributable to one address. Instruction bits 13:10 play no part in any check, and the bench holds them at zero.

// File: rtl/dar_pkg.sv
package dar_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FILE_W  = 7;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned INSTR_W = 14;
  localparam int unsigned BITNO_W = 3;
  localparam int unsigned BITNO_LSB = 7;

  typedef enum logic [3:0] {
    RG_NONE      = 4'd0,
    RG_GPR       = 4'd1,
    RG_PC_LO     = 4'd2,
    RG_STATUS    = 4'd3,
    RG_PTR       = 4'd4,
    RG_PORT_A    = 4'd5,
    RG_PORT_B    = 4'd6,
    RG_PORT_C    = 4'd7,
    RG_PORT_D    = 4'd8,
    RG_DIR_A     = 4'd9,
    RG_DIR_B     = 4'd10,
    RG_DIR_C     = 4'd11,
    RG_DIR_D     = 4'd12,
    RG_PC_HI_LAT = 4'd13,
    RG_IRQ_CTL   = 4'd14,
    RG_OPT       = 4'd15
  } region_e;
endpackage

// File: rtl/dar_addr_sel.sv
module dar_addr_sel #(
  parameter int unsigned FILE_W = dar_pkg::FILE_W,
  parameter int unsigned DATA_W = dar_pkg::DATA_W,
  localparam int unsigned ADDR_W = DATA_W + 1
) (
  input  logic [FILE_W-1:0] file_i,
  input  logic [1:0]        dir_bank_i,
  input  logic              ind_bank_i,
  input  logic [DATA_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              indirect_o
);
  // file field zero is a virtual location standing for the pointer target
  assign indirect_o = (file_i == '0);

  always_comb begin
    if (indirect_o) addr_o = {ind_bank_i, ptr_i};
    else            addr_o = {dir_bank_i, file_i};
  end
endmodule

// File: rtl/dar_region_dec.sv
module dar_region_dec
  import dar_pkg::*;
#(
  parameter int unsigned DATA_W = dar_pkg::DATA_W,
  parameter logic [6:0]  GPR_BASE = 7'h0E
) (
  input  logic [DATA_W-1:0] low_i,
  output region_e           region_o
);
  logic       hi_half;
  logic [6:0] off;

  assign hi_half = low_i[7];
  assign off     = low_i[6:0];

  always_comb begin
    region_o = RG_NONE;
    if (off >= GPR_BASE) begin
      region_o = RG_GPR;
    end else begin
      case (off)
        7'h02: region_o = RG_PC_LO;
        7'h03: region_o = RG_STATUS;
        7'h04: region_o = RG_PTR;
        7'h0A: region_o = RG_PC_HI_LAT;
        7'h0B: region_o = RG_IRQ_CTL;
        7'h01: region_o = hi_half ? RG_OPT    : RG_NONE;
        7'h05: region_o = hi_half ? RG_DIR_A  : RG_PORT_A;
        7'h06: region_o = hi_half ? RG_DIR_B  : RG_PORT_B;
        7'h0C: region_o = hi_half ? RG_DIR_C  : RG_PORT_C;
        7'h0D: region_o = hi_half ? RG_DIR_D  : RG_PORT_D;
        default: region_o = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dar_bit_mask.sv
module dar_bit_mask #(
  parameter int unsigned DATA_W  = dar_pkg::DATA_W,
  parameter int unsigned BITNO_W = dar_pkg::BITNO_W
) (
  input  logic [BITNO_W-1:0] bitno_i,
  output logic [DATA_W-1:0]  mask_o,
  output logic [DATA_W-1:0]  mask_n_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask_o[i]   = (bitno_i == BITNO_W'(i));
    assign mask_n_o[i] = ~mask_o[i];
  end
endmodule

// File: rtl/dmem_addr_resolver.sv
module dmem_addr_resolver
  import dar_pkg::*;
#(
  parameter int unsigned INSTR_W   = dar_pkg::INSTR_W,
  parameter int unsigned DATA_W    = dar_pkg::DATA_W,
  parameter int unsigned FILE_W    = dar_pkg::FILE_W,
  parameter int unsigned BITNO_W   = dar_pkg::BITNO_W,
  parameter int unsigned BITNO_LSB = dar_pkg::BITNO_LSB,
  localparam int unsigned ADDR_W   = DATA_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  status_i,
  input  logic [DATA_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  input  logic               ld_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               indirect_o,
  output logic [3:0]         region_o,
  output logic [DATA_W-1:0]  operand_o,
  output logic [DATA_W-1:0]  bit_mask_o,
  output logic [DATA_W-1:0]  bit_mask_n_o
);
  region_e           region;
  logic [DATA_W-1:0] operand_q;

  dar_addr_sel #(.FILE_W(FILE_W), .DATA_W(DATA_W)) i_addr_sel (
    .file_i     (instr_i[FILE_W-1:0]),
    .dir_bank_i (status_i[6:5]),
    .ind_bank_i (status_i[7]),
    .ptr_i      (ptr_i),
    .addr_o     (addr_o),
    .indirect_o (indirect_o)
  );

  dar_region_dec #(.DATA_W(DATA_W)) i_region_dec (
    .low_i    (addr_o[DATA_W-1:0]),
    .region_o (region)
  );

  dar_bit_mask #(.DATA_W(DATA_W), .BITNO_W(BITNO_W)) i_bit_mask (
    .bitno_i  (instr_i[BITNO_LSB +: BITNO_W]),
    .mask_o   (bit_mask_o),
    .mask_n_o (bit_mask_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   operand_q <= '0;
    else if (ld_i) operand_q <= (region == RG_NONE) ? '0 : rd_data_i;
  end

  assign region_o  = region;
  assign operand_o = operand_q;
endmodule

// File: rtl/dar_checker.sv
module dar_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [13:0] instr_i,
  input logic [7:0]  status_i,
  input logic [7:0]  ptr_i,
  input logic [7:0]  rd_data_i,
  input logic        ld_i,
  input logic [8:0]  addr_o,
  input logic        indirect_o,
  input logic [3:0]  region_o,
  input logic [7:0]  operand_o,
  input logic [7:0]  bit_mask_o,
  input logic [7:0]  bit_mask_n_o
);
  a_r1_direct_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[6:0] != 7'd0) |-> (!indirect_o && addr_o[8:7] == status_i[6:5]));

  a_r2_indirect_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    indirect_o |-> (addr_o == {status_i[7], ptr_i}));

  a_r4_sram_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[6:0] >= 7'h0E) |-> (region_o == 4'd1));

  a_r7_low_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[7:0] == 8'h00 || addr_o[7:0] == 8'h80) |-> (region_o == 4'd0));

  a_r8_zero_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && region_o == 4'd0) |=> (operand_o == 8'd0));

  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && region_o != 4'd0) |=> (operand_o == $past(rd_data_i)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(operand_o));

  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(bit_mask_o) == 1) && bit_mask_o[instr_i[9:7]]);

  a_r9_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_mask_o ^ bit_mask_n_o) == 8'hFF);

  always_comb begin
    if (!rst_ni) a_r10_reset_zero: assert (operand_o == 8'd0);
  end
endmodule

bind dmem_addr_resolver dar_checker i_dar_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_i      (instr_i),
  .status_i     (status_i),
  .ptr_i        (ptr_i),
  .rd_data_i    (rd_data_i),
  .ld_i         (ld_i),
  .addr_o       (addr_o),
  .indirect_o   (indirect_o),
  .region_o     (region_o),
  .operand_o    (operand_o),
  .bit_mask_o   (bit_mask_o),
  .bit_mask_n_o (bit_mask_n_o)
);

// File: tb/test_dmem_addr_resolver.sv
module test_dmem_addr_resolver;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] instr_i = '0;
  logic [7:0]  status_i = '0;
  logic [7:0]  ptr_i = '0;
  logic [7:0]  rd_data_i = '0;
  logic        ld_i = 1'b0;
  logic [8:0]  addr_o;
  logic        indirect_o;
  logic [3:0]  region_o;
  logic [7:0]  operand_o;
  logic [7:0]  bit_mask_o;
  logic [7:0]  bit_mask_n_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dmem_addr_resolver i_dmem_addr_resolver (
    .clk_i, .rst_ni, .instr_i, .status_i, .ptr_i, .rd_data_i, .ld_i,
    .addr_o, .indirect_o, .region_o, .operand_o, .bit_mask_o, .bit_mask_n_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive a direct access: 2 bank bits, 7-bit offset
  task automatic drive(input logic [1:0] bank, input logic [6:0] file, input logic [2:0] bitno);
    @(negedge clk_i);
    status_i = {status_i[7], bank, status_i[4:0]};
    instr_i  = {4'b0, bitno, file};
    #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    rd_data_i = 8'h5A;
    ld_i = 1'b1;
    @(posedge clk_i); #1;
    chk(operand_o == 8'h00, "R10", operand_o, 0);
    @(negedge clk_i);
    ld_i = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_direct();
    status_i = 8'h80;
    drive(2'b11, 7'h25, 3'd0);
    chk(addr_o == 9'h1A5 && !indirect_o, "R1", addr_o, 9'h1A5);
    status_i = 8'h00;
    drive(2'b11, 7'h25, 3'd0);
    chk(addr_o == 9'h1A5, "R1", addr_o, 9'h1A5);
    drive(2'b01, 7'h7F, 3'd0);
    chk(addr_o == 9'h0FF && !indirect_o, "R1", addr_o, 9'h0FF);
  endtask

  task automatic t_indirect();
    @(negedge clk_i);
    ptr_i = 8'h8C;
    status_i = 8'hA0;
    instr_i = 14'h0000;
    #1;
    chk(indirect_o == 1'b1, "R2", indirect_o, 1);
    chk(addr_o == 9'h18C, "R2", addr_o, 9'h18C);
    chk(region_o == 4'd11, "R3", region_o, 11);
    status_i = 8'hC0;
    #1;
    chk(addr_o == 9'h18C, "R2", addr_o, 9'h18C);
    status_i = 8'h00;
    ptr_i = 8'h03;
    #1;
    chk(addr_o == 9'h003 && region_o == 4'd3, "R2", addr_o, 9'h003);
  endtask

  task automatic t_sram();
    drive(2'b00, 7'h0E, 3'd0); chk(region_o == 4'd1, "R4", region_o, 1);
    drive(2'b00, 7'h7F, 3'd0); chk(region_o == 4'd1, "R4", region_o, 1);
    drive(2'b01, 7'h0E, 3'd0); chk(region_o == 4'd1, "R4", region_o, 1);
    drive(2'b11, 7'h40, 3'd0); chk(region_o == 4'd1, "R4", region_o, 1);
    drive(2'b00, 7'h0D, 3'd0); chk(region_o == 4'd8, "R6", region_o, 8);
  endtask

  task automatic t_mirror();
    logic [6:0] offs [5] = '{7'h02, 7'h03, 7'h04, 7'h0A, 7'h0B};
    logic [3:0] codes [5] = '{4'd2, 4'd3, 4'd4, 4'd13, 4'd14};
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 5; k++) begin
        drive(2'(b), offs[k], 3'd0);
        chk(region_o == codes[k], "R5", region_o, codes[k]);
      end
    end
    // bank bit 8 does not alter decode (R3)
    drive(2'b10, 7'h05, 3'd0);
    chk(region_o == 4'd5, "R3", region_o, 5);
    drive(2'b11, 7'h05, 3'd0);
    chk(region_o == 4'd9, "R3", region_o, 9);
  endtask

  task automatic t_banked();
    drive(2'b00, 7'h05, 3'd0); chk(region_o == 4'd5,  "R6", region_o, 5);
    drive(2'b00, 7'h06, 3'd0); chk(region_o == 4'd6,  "R6", region_o, 6);
    drive(2'b00, 7'h0C, 3'd0); chk(region_o == 4'd7,  "R6", region_o, 7);
    drive(2'b01, 7'h05, 3'd0); chk(region_o == 4'd9,  "R6", region_o, 9);
    drive(2'b01, 7'h06, 3'd0); chk(region_o == 4'd10, "R6", region_o, 10);
    drive(2'b01, 7'h0C, 3'd0); chk(region_o == 4'd11, "R6", region_o, 11);
    drive(2'b01, 7'h0D, 3'd0); chk(region_o == 4'd12, "R6", region_o, 12);
    drive(2'b01, 7'h01, 3'd0); chk(region_o == 4'd15, "R6", region_o, 15);
  endtask

  task automatic t_unmapped();
    drive(2'b00, 7'h01, 3'd0); chk(region_o == 4'd0, "R7", region_o, 0);
    drive(2'b00, 7'h07, 3'd0); chk(region_o == 4'd0, "R7", region_o, 0);
    drive(2'b01, 7'h09, 3'd0); chk(region_o == 4'd0, "R7", region_o, 0);
    @(negedge clk_i);
    instr_i = 14'h0000;
    status_i = 8'h80;
    ptr_i = 8'h00;
    rd_data_i = 8'hAB;
    ld_i = 1'b1;
    #1;
    chk(region_o == 4'd0 && addr_o == 9'h100, "R7", region_o, 0);
    @(posedge clk_i); #1;
    chk(operand_o == 8'h00, "R7", operand_o, 0);
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic t_operand();
    drive(2'b00, 7'h20, 3'd0);
    rd_data_i = 8'hC3;
    ld_i = 1'b1;
    @(posedge clk_i); #1;
    chk(operand_o == 8'hC3, "R8", operand_o, 8'hC3);
    @(negedge clk_i);
    ld_i = 1'b0;
    rd_data_i = 8'h3C;
    @(posedge clk_i); #1;
    chk(operand_o == 8'hC3, "R8", operand_o, 8'hC3);
    drive(2'b00, 7'h07, 3'd0);
    @(posedge clk_i); #1;
    chk(operand_o == 8'hC3, "R8", operand_o, 8'hC3);
    drive(2'b01, 7'h01, 3'd0);
    rd_data_i = 8'h91;
    ld_i = 1'b1;
    @(posedge clk_i); #1;
    chk(operand_o == 8'h91, "R8", operand_o, 8'h91);
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic t_mask();
    for (int b = 0; b < 8; b++) begin
      drive(2'b00, 7'h30, 3'(b));
      chk(bit_mask_o == 8'(1 << b), "R9", bit_mask_o, 1 << b);
      chk(bit_mask_n_o == ~8'(1 << b), "R9", bit_mask_n_o, ~(1 << b) & 8'hFF);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_indirect();
    t_sram();
    t_mirror();
    t_banked();
    t_unmapped();
    t_operand();
    t_mask();
    repeat (2) @(posedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule